// File: doc/BRIEF.md
# Exception Mask and Priority Arbiter

This block chooses which pending exception the processor core takes next and names the vector for it. It owns the two mask bits of the condition register. One is a global mask for the maskable requests. The other masks a pseudo non-maskable external request. The core presents its request lines, its trap strobes and an instruction-boundary flag. At a boundary, the block compares each request with the current masks and picks a single winner. In the following cycle it raises a one-cycle take strobe with a registered vector index, and it updates the mask bits as the service entry requires.

The core also writes the mask bits. It does this for a software transfer to the condition register, and again on a return from an interrupt, when it restores the stacked copy. The external-request mask is one-way for software: a write can clear it, but no write can set it again. The block stops granting anything else from the moment a software-interrupt trap is accepted until the core reports that the first instruction of that handler has finished.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst` is high, `x_mask` and `i_mask` are 1, and `take_irq` is 1 with `vec_idx` 0 (the reset vector). With both masks set, neither `xirq_req` nor `irq_req` is ever granted.
- R2: A mask write (`msk_wr`) with `msk_wr_x`=0 clears `x_mask`. No mask write can later set `x_mask`; only reset or entry into external-request service sets it.
- R3: A write to the maskable-interrupt bit has no effect on `x_mask`. While `x_mask` is 0, `xirq_req` is granted even when `i_mask` is 1.
- R4: `xirq_req` (vector 3) wins over every maskable request. Among `irq_req` bits, a lower bit index wins, and bit k uses vector 4+k.
- R5: Any granted entry, the software trap included, leaves `i_mask` at 1 in the cycle `take_irq` is high.
- R6: `swi_req` is granted (vector 2) only when no unmasked external or maskable request is pending in the same boundary cycle. Otherwise the pending request wins.
- R7: After a software trap is granted, no request of any kind is granted until `first_insn_done` has pulsed.
- R8: `irq_req[RTI_IDX]`, the periodic timer source, is granted only when `rti_en` is 1 and `i_mask` is 0.
- R9: A request is granted only on a clock edge where `at_boundary` is 1. The grant appears one cycle later as a single-cycle `take_irq`.
- R10: `illop_req` is granted with vector 1 regardless of both masks, and it wins over every other source.
- R11: Entering external-request service sets both `x_mask` and `i_mask`. If software had cleared `x_mask` earlier, a later mask write (such as the return restore) clears it again even when the written value is 1.
- R12: When an entry and a mask write fall on the same edge, the entry decides the mask bits and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| at_boundary | input | 1 | Core is at an instruction boundary |
| xirq_req | input | 1 | Pseudo non-maskable external request |
| irq_req | input | N_IRQ | Maskable requests, bit 0 highest priority |
| rti_en | input | 1 | Local enable of the periodic timer request |
| swi_req | input | 1 | Software-interrupt instruction strobe |
| illop_req | input | 1 | Illegal-opcode detect strobe |
| msk_wr | input | 1 | Mask write (transfer or return restore) |
| msk_wr_x | input | 1 | Written value of the external mask bit |
| msk_wr_i | input | 1 | Written value of the maskable mask bit |
| first_insn_done | input | 1 | First handler instruction completed |
| take_irq | output | 1 | Take-exception strobe |
| vec_idx | output | VEC_W | Vector index of the taken exception |
| x_mask | output | 1 | External-request mask bit |
| i_mask | output | 1 | Maskable-interrupt mask bit |

## Verification
The bench tries to set `x_mask` again in three ways: a direct write of 1, a write that changes only the maskable bit, and a return restore with a stacked 1 after external-request service. A design with a two-way X bit would show `x_mask` at 1 after any of these. It offers the software trap together with a pending maskable request, and it sends an illegal-opcode strobe while the software-trap lockout is active. A design without the yield rule would report vector 2 in the first case, and one without the lockout would grant the illegal opcode early. It also holds the periodic timer request with its local enable low, and offers requests with `at_boundary` low. A design that ignores either gate takes an interrupt there.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int VEC_RESET = 0;
  localparam int VEC_ILLOP = 1;
  localparam int VEC_SWI   = 2;
  localparam int VEC_XIRQ  = 3;
  localparam int VEC_MASK0 = 4;

  function automatic int vec_width(input int n_irq);
    return $clog2(n_irq + VEC_MASK0);
  endfunction
endpackage

// File: rtl/irq_source_select.sv
module irq_source_select
  import irq_arb_pkg::*;
#(
  parameter int N_IRQ   = 4,
  parameter int RTI_IDX = 1,
  parameter int VEC_W   = vec_width(N_IRQ)
) (
  input  logic             x_mask,
  input  logic             i_mask,
  input  logic             xirq_req,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             rti_en,
  input  logic             swi_req,
  input  logic             illop_req,
  output logic             sel_valid,
  output logic [VEC_W-1:0] sel_vec,
  output logic             others_pending
);
  logic [N_IRQ-1:0] irq_gated;
  logic             xirq_ok;
  logic             mask_any;
  logic [VEC_W-1:0] mask_vec;

  // local enable only on the periodic timer line
  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_gate
      if (g == RTI_IDX) begin : g_rti
        assign irq_gated[g] = irq_req[g] & rti_en & ~i_mask;
      end else begin : g_plain
        assign irq_gated[g] = irq_req[g] & ~i_mask;
      end
    end
  endgenerate

  assign xirq_ok  = xirq_req & ~x_mask;
  assign mask_any = |irq_gated;

  // lowest index wins
  always_comb begin
    mask_vec = VEC_W'(VEC_MASK0);
    for (int k = N_IRQ - 1; k >= 0; k--) begin
      if (irq_gated[k]) mask_vec = VEC_W'(VEC_MASK0 + k);
    end
  end

  assign others_pending = xirq_ok | mask_any;

  always_comb begin
    sel_valid = 1'b1;
    if (illop_req)       sel_vec = VEC_W'(VEC_ILLOP);
    else if (xirq_ok)    sel_vec = VEC_W'(VEC_XIRQ);
    else if (mask_any)   sel_vec = mask_vec;
    else if (swi_req)    sel_vec = VEC_W'(VEC_SWI);
    else begin
      sel_valid = 1'b0;
      sel_vec   = VEC_W'(VEC_RESET);
    end
  end
endmodule

// File: rtl/irq_grant_ctrl.sv
module irq_grant_ctrl
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             at_boundary,
  input  logic             sel_valid,
  input  logic [VEC_W-1:0] sel_vec,
  input  logic             first_insn_done,
  output logic             entry,
  output logic             entry_xirq,
  output logic             take_q,
  output logic [VEC_W-1:0] vec_q
);
  logic lock_q;

  assign entry      = at_boundary & sel_valid & ~lock_q;
  assign entry_xirq = entry & (sel_vec == VEC_W'(VEC_XIRQ));

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b1;
      vec_q  <= VEC_W'(VEC_RESET);
      lock_q <= 1'b0;
    end else begin
      take_q <= entry;
      if (entry) vec_q <= sel_vec;
      if (entry && sel_vec == VEC_W'(VEC_SWI)) lock_q <= 1'b1;
      else if (first_insn_done)                lock_q <= 1'b0;
    end
  end

  p_swi_lockout_r7: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> !take_q);

  p_grant_at_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    (take_q && vec_q != VEC_W'(VEC_RESET)) |-> $past(at_boundary));
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs (
  input  logic clk,
  input  logic rst,
  input  logic entry,
  input  logic entry_xirq,
  input  logic wr,
  input  logic wr_x,
  input  logic wr_i,
  output logic x_q,
  output logic i_q
);
  logic x_cleared_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q         <= 1'b1;
      i_q         <= 1'b1;
      x_cleared_q <= 1'b0;
    end else if (entry) begin
      i_q <= 1'b1;
      if (entry_xirq) x_q <= 1'b1;
    end else if (wr) begin
      i_q <= wr_i;
      x_q <= x_q & wr_x & ~x_cleared_q;
      if (!wr_x) x_cleared_q <= 1'b1;
    end
  end

  p_x_set_only_by_hw_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(x_q) |-> $past(entry_xirq));

  p_entry_sets_i_r5: assert property (@(posedge clk) disable iff (rst)
    entry |=> i_q);

  p_restore_keeps_x_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (x_cleared_q && wr && !entry) |=> !x_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_IRQ   = 4,
  parameter int RTI_IDX = 1,
  localparam int VEC_W  = vec_width(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             at_boundary,
  input  logic             xirq_req,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             rti_en,
  input  logic             swi_req,
  input  logic             illop_req,
  input  logic             msk_wr,
  input  logic             msk_wr_x,
  input  logic             msk_wr_i,
  input  logic             first_insn_done,
  output logic             take_irq,
  output logic [VEC_W-1:0] vec_idx,
  output logic             x_mask,
  output logic             i_mask
);
  logic             sel_valid;
  logic [VEC_W-1:0] sel_vec;
  logic             others_pending;
  logic             entry;
  logic             entry_xirq;

  irq_source_select #(.N_IRQ(N_IRQ), .RTI_IDX(RTI_IDX), .VEC_W(VEC_W)) u_sel (
    .x_mask(x_mask), .i_mask(i_mask), .xirq_req(xirq_req), .irq_req(irq_req),
    .rti_en(rti_en), .swi_req(swi_req), .illop_req(illop_req),
    .sel_valid(sel_valid), .sel_vec(sel_vec), .others_pending(others_pending)
  );

  irq_grant_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rst(rst), .at_boundary(at_boundary), .sel_valid(sel_valid),
    .sel_vec(sel_vec), .first_insn_done(first_insn_done), .entry(entry),
    .entry_xirq(entry_xirq), .take_q(take_irq), .vec_q(vec_idx)
  );

  irq_mask_regs u_msk (
    .clk(clk), .rst(rst), .entry(entry), .entry_xirq(entry_xirq),
    .wr(msk_wr), .wr_x(msk_wr_x), .wr_i(msk_wr_i), .x_q(x_mask), .i_q(i_mask)
  );

  p_xirq_beats_maskable_r4: assert property (@(posedge clk) disable iff (rst)
    (take_irq && vec_idx >= VEC_W'(VEC_MASK0)) |-> !$past(xirq_req && !x_mask));

  p_swi_yields_r6: assert property (@(posedge clk) disable iff (rst)
    (take_irq && vec_idx == VEC_W'(VEC_SWI)) |-> !$past(others_pending));
endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ = 4;
  localparam int RTI_IDX = 1;
  localparam int VEC_W = $clog2(N_IRQ + 4);

  logic clk = 1'b0;
  logic rst, at_boundary, xirq_req, rti_en, swi_req, illop_req;
  logic msk_wr, msk_wr_x, msk_wr_i, first_insn_done;
  logic [N_IRQ-1:0] irq_req;
  logic take_irq, x_mask, i_mask;
  logic [VEC_W-1:0] vec_idx;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_arbiter #(.N_IRQ(N_IRQ), .RTI_IDX(RTI_IDX)) dut (
    .clk(clk), .rst(rst), .at_boundary(at_boundary), .xirq_req(xirq_req),
    .irq_req(irq_req), .rti_en(rti_en), .swi_req(swi_req), .illop_req(illop_req),
    .msk_wr(msk_wr), .msk_wr_x(msk_wr_x), .msk_wr_i(msk_wr_i),
    .first_insn_done(first_insn_done), .take_irq(take_irq), .vec_idx(vec_idx),
    .x_mask(x_mask), .i_mask(i_mask)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    at_boundary = 0; xirq_req = 0; irq_req = '0; swi_req = 0; illop_req = 0;
    msk_wr = 0; msk_wr_x = 0; msk_wr_i = 0; first_insn_done = 0;
  endtask

  // one edge: inputs are set before the call at negedge, outputs sampled at next negedge
  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic wmask(input logic x, input logic i);
    msk_wr = 1; msk_wr_x = x; msk_wr_i = i;
    cyc();
  endtask

  task automatic t_reset();
    rst = 1; rti_en = 0; idle();
    cyc(); cyc();
    chk("R1 x", x_mask, 1); chk("R1 i", i_mask, 1);
    chk("R1 take", take_irq, 1); chk("R1 vec", vec_idx, 0);
    rst = 0; cyc();
    at_boundary = 1; xirq_req = 1; irq_req = 4'b1111; rti_en = 1;
    cyc();
    chk("R1 masked no take", take_irq, 0);
  endtask

  task automatic t_x_one_way();
    wmask(0, 1);
    chk("R2 x cleared", x_mask, 0); chk("R3 i kept", i_mask, 1);
    wmask(1, 1);
    chk("R2 x not set", x_mask, 0);
    wmask(0, 0);
    chk("R3 i cleared", i_mask, 0); chk("R3 x unchanged", x_mask, 0);
    wmask(0, 1);
  endtask

  task automatic t_xirq_with_i_set();
    at_boundary = 1; xirq_req = 1; cyc();
    chk("R3 xirq take", take_irq, 1); chk("R3 xirq vec", vec_idx, 3);
    chk("R11 x set", x_mask, 1); chk("R11 i set", i_mask, 1);
    cyc(); chk("R9 single pulse", take_irq, 0);
    wmask(1, 0);
    chk("R11 restore x clear", x_mask, 0); chk("R11 restore i", i_mask, 0);
  endtask

  task automatic t_priority();
    at_boundary = 1; xirq_req = 1; irq_req = 4'b0101; cyc();
    chk("R4 xirq wins", vec_idx, 3); chk("R4 take", take_irq, 1);
    wmask(0, 0);
    at_boundary = 1; irq_req = 4'b1100; cyc();
    chk("R4 low index wins", vec_idx, 6); chk("R5 i set", i_mask, 1);
    wmask(0, 0);
  endtask

  task automatic t_rti_gate();
    rti_en = 0; at_boundary = 1; irq_req = 4'b0010; cyc();
    chk("R8 rti disabled", take_irq, 0);
    rti_en = 1; at_boundary = 1; irq_req = 4'b0010; cyc();
    chk("R8 rti take", take_irq, 1); chk("R8 rti vec", vec_idx, 5);
    wmask(0, 0);
  endtask

  task automatic t_boundary();
    irq_req = 4'b0001; xirq_req = 1; cyc();
    chk("R9 no boundary", take_irq, 0);
    chk("R9 masks unchanged", i_mask, 0);
  endtask

  task automatic t_swi();
    at_boundary = 1; swi_req = 1; irq_req = 4'b0001; cyc();
    chk("R6 swi yields", vec_idx, 4);
    wmask(0, 0);
    at_boundary = 1; swi_req = 1; cyc();
    chk("R6 swi vec", vec_idx, 2); chk("R5 swi sets i", i_mask, 1);
    at_boundary = 1; illop_req = 1; cyc();
    chk("R7 locked out", take_irq, 0);
    first_insn_done = 1; cyc();
    at_boundary = 1; illop_req = 1; cyc();
    chk("R7 after done", take_irq, 1); chk("R10 illop vec", vec_idx, 1);
  endtask

  task automatic t_illop_and_clash();
    at_boundary = 1; illop_req = 1; xirq_req = 1; irq_req = 4'b0001; cyc();
    chk("R10 illop wins", vec_idx, 1); chk("R10 take", take_irq, 1);
    wmask(0, 0);
    at_boundary = 1; irq_req = 4'b1000; msk_wr = 1; msk_wr_x = 0; msk_wr_i = 0; cyc();
    chk("R12 entry beats write", i_mask, 1); chk("R12 vec", vec_idx, 7);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_x_one_way();
    t_xirq_with_i_set();
    t_priority();
    t_rti_gate();
    t_boundary();
    t_swi();
    t_illop_and_clash();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule